// File: doc/BRIEF.md
# Three-Phase Complementary PWM Timer

This block generates three pairs of complementary PWM waveforms from a single up-counter, for driving a three-phase bridge. The counter climbs from zero on every prescaled tick. When it holds the period value on a tick it returns to zero, so the period register alone fixes the cycle length. Each phase has its own compare value, which places that phase's falling transition inside the cycle. Each phase drives a positive pin and a negative pin. Before polarity is applied, the negative pin carries the exact logical inverse of the positive pin.

Software sets the block up while the counter is stopped. One write strobe loads the period, the three compare values, the prescaler choice, two polarity bits, the cycle-toggle enable and seven per-pin enables. A clear strobe can return the counter to zero before counting resumes. Raising `run` starts counting and lowering it freezes the counter. The block ignores set-up strobes while `run` is high. A seventh pin can be enabled to invert once per PWM cycle.

Top module: `tri_pwm_top`

## Requirements
- R1: On each tick the counter advances by one. On a tick where the counter equals the period P, it goes to zero instead, so one PWM cycle lasts P+1 ticks. The counter is zero after reset.
- R2: For a compare value C below P, the internal phase state becomes active (1) on the tick that wraps the counter to zero. It becomes inactive (0) on the tick taken while the counter equals C. From the first wrap onward it is therefore 1 while the count is 0..C and 0 while the count is C+1..P. Before the first wrap after reset it is 0.
- R3: When a compare value equals P, that phase state inverts on every wrap tick.
- R4: When polarity bit `cfg_pol_p` is 1, a positive pin shows the phase state; when it is 0, the pin shows the inverse. When `cfg_pol_n` is 1, a negative pin shows the inverse of the phase state; when it is 0, it shows the phase state itself.
- R5: Pin-enable bits [2:0] gate the positive pins of phases 0..2, bits [5:3] gate the negative pins, and bit [6] gates the cycle-toggle pin. A disabled phase pin drives its inactive level, which is 0 when its polarity bit is 1 and 1 when it is 0. A disabled cycle-toggle pin drives 0.
- R6: When the toggle enable is 1, the cycle-toggle state starts at 0 after reset and inverts on every wrap tick. When the enable is 0, the state holds.
- R7: `cfg_presc` values 0, 1, 2 and 3 select a tick on every 1st, 4th, 16th or 64th clock edge with `run` high. The prescaler phase is zero after reset, so the first tick comes on the d-th such edge.
- R8: `cfg_we` loads all set-up fields only on a clock edge where `run` is 0. The block ignores `cfg_we` and `cfg_clr` while `run` is 1.
- R9: `cfg_clr` with `run` at 0 returns the counter and the prescaler phase to zero. It leaves the phase and cycle-toggle states unchanged.
- R10: While `run` is 0, the counter, the phase states and the cycle-toggle state hold. Without a set-up write, every output pin stays stable.
- R11: After reset the set-up fields are P=0, all C=0, both polarity bits 1, toggle disabled and all pins disabled, so every output pin is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Count enable: 1 counts, 0 halts |
| cfg_we | input | 1 | Set-up write strobe, honoured only while halted |
| cfg_clr | input | 1 | Counter and prescaler clear, honoured only while halted |
| cfg_presc | input | 2 | Prescaler select: 0=/1, 1=/4, 2=/16, 3=/64 |
| cfg_period | input | CW | Period value P |
| cfg_cmp | input | NPH*CW | Compare values, phase i in bits [i*CW +: CW] |
| cfg_pol_p | input | 1 | Positive-pin polarity |
| cfg_pol_n | input | 1 | Negative-pin polarity |
| cfg_tgl_en | input | 1 | Cycle-toggle enable |
| cfg_pin_en | input | 2*NPH+1 | Per-pin output enables |
| pha_p | output | NPH | Positive phase pins |
| pha_n | output | NPH | Negative phase pins |
| cyc_tgl | output | 1 | Cycle-toggle pin |

## Verification
The assertions assume that every compare value is at most the period. This keeps compare and wrap events in their normal order, and the stimulus only ever loads C in 0..P. They also assume that the prescaler choice changes only through a halted write. The bench makes every set-up write with `run` low, except the deliberate writes during a run that check R8. The bench resets before each sweep point, so the phase state begins at 0. This lets it predict the pins arithmetically from the tick count, the period and each compare value.

// File: rtl/tpwm_pkg.sv
// Package: shared types and helpers for the three-phase PWM timer.
// Assumes a prescaler of at most /64, so six phase bits are enough.
package tpwm_pkg;
    localparam int unsigned PRE_W = 6;

    typedef enum logic [1:0] {
        DIV1  = 2'd0,
        DIV4  = 2'd1,
        DIV16 = 2'd2,
        DIV64 = 2'd3
    } presc_e;

    // Low-bit mask that must be all ones in the prescaler phase for a tick.
    function automatic logic [PRE_W-1:0] presc_mask(presc_e sel);
        case (sel)
            DIV1:    return 6'd0;
            DIV4:    return 6'd3;
            DIV16:   return 6'd15;
            default: return 6'd63;
        endcase
    endfunction
endpackage

// File: rtl/tpwm_cfg.sv
// Set-up register bank. Loads every field on a write strobe only while the
// counter is halted, and forwards the clear strobe only while halted.
// Assumes the strobes are synchronous to clk.
module tpwm_cfg #(
    parameter int unsigned CW  = 8,
    parameter int unsigned NPH = 3,
    localparam int unsigned ENW = 2*NPH + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              we,
    input  logic              clr_req,
    input  logic [1:0]        presc_i,
    input  logic [CW-1:0]     prd_i,
    input  logic [NPH*CW-1:0] cmp_i,
    input  logic              pol_p_i,
    input  logic              pol_n_i,
    input  logic              tgl_en_i,
    input  logic [ENW-1:0]    en_i,
    output tpwm_pkg::presc_e  presc_o,
    output logic [CW-1:0]     prd_o,
    output logic [NPH*CW-1:0] cmp_o,
    output logic              pol_p_o,
    output logic              pol_n_o,
    output logic              tgl_en_o,
    output logic [ENW-1:0]    en_o,
    output logic              clr_o
);
    logic load;
    assign load  = we & ~run;
    assign clr_o = clr_req & ~run;

    // Capture the set-up fields on a halted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_o  <= tpwm_pkg::DIV1;
            prd_o    <= '0;
            cmp_o    <= '0;
            pol_p_o  <= 1'b1;
            pol_n_o  <= 1'b1;
            tgl_en_o <= 1'b0;
            en_o     <= '0;
        end else if (load) begin
            presc_o  <= tpwm_pkg::presc_e'(presc_i);
            prd_o    <= prd_i;
            cmp_o    <= cmp_i;
            pol_p_o  <= pol_p_i;
            pol_n_o  <= pol_n_i;
            tgl_en_o <= tgl_en_i;
            en_o     <= en_i;
        end
    end

    // R8
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> ($stable(prd_o) && $stable(cmp_o) && $stable(en_o) && $stable(presc_o)));
endmodule

// File: rtl/tpwm_tick.sv
// Prescaler. Produces a one-clock tick every 1, 4, 16 or 64 running clocks.
// Assumes the select changes only while halted; the phase holds when halted.
module tpwm_tick (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  tpwm_pkg::presc_e sel,
    output logic             tick
);
    import tpwm_pkg::*;

    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] mask;

    assign mask = presc_mask(sel);
    assign tick = run & ((phase_q & mask) == mask);

    // Advance the prescaler phase on running clocks.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= phase_q + PRE_W'(1);
        end
    end

    // R7
    div_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel != DIV1) |=> !tick);
endmodule

// File: rtl/tpwm_count.sv
// Period counter. Advances on ticks, returns to zero on the tick that finds
// it equal to the period, and flags that tick as the wrap event.
// Assumes the clear arrives only while halted.
module tpwm_count #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          clr,
    input  logic [CW-1:0] prd,
    output logic [CW-1:0] cnt,
    output logic          wrap
);
    assign wrap = tick & (cnt == prd);

    // Count ticks, wrapping at the period.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= wrap ? '0 : cnt + CW'(1);
        end
    end

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wrap && !clr) |=> (cnt == $past(cnt) + CW'(1)));
    // R1
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0));
    // R10
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(cnt));
endmodule

// File: rtl/tpwm_phase.sv
// One phase state bit. Goes active on a wrap, inactive on its compare match,
// and inverts on a wrap when the compare equals the period.
// Assumes the compare value never exceeds the period.
module tpwm_phase #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wrap,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cmp,
    input  logic [CW-1:0] prd,
    output logic          state
);
    logic full_duty;
    assign full_duty = (cmp == prd);

    // Update the phase state on tick events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= 1'b0;
        end else if (tick) begin
            if (wrap && full_duty) begin
                state <= ~state;
            end else if (wrap) begin
                state <= 1'b1;
            end else if (cnt == cmp) begin
                state <= 1'b0;
            end
        end
    end

    // R2
    rise_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state) |-> $past(wrap));
    // R10
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(state));
endmodule

// File: rtl/tri_pwm_top.sv
// Three-phase complementary PWM timer top. Joins the set-up bank, the
// prescaler, the shared period counter, one state bit per phase, the
// cycle-toggle bit and the polarity/enable output stage.
// Assumes each compare value is at most the period.
module tri_pwm_top #(
    parameter int unsigned CW  = 8,
    parameter int unsigned NPH = 3,
    localparam int unsigned ENW = 2*NPH + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              cfg_we,
    input  logic              cfg_clr,
    input  logic [1:0]        cfg_presc,
    input  logic [CW-1:0]     cfg_period,
    input  logic [NPH*CW-1:0] cfg_cmp,
    input  logic              cfg_pol_p,
    input  logic              cfg_pol_n,
    input  logic              cfg_tgl_en,
    input  logic [ENW-1:0]    cfg_pin_en,
    output logic [NPH-1:0]    pha_p,
    output logic [NPH-1:0]    pha_n,
    output logic              cyc_tgl
);
    tpwm_pkg::presc_e  presc_q;
    logic [CW-1:0]     prd_q;
    logic [NPH*CW-1:0] cmp_q;
    logic              pol_p_q, pol_n_q, tgl_en_q;
    logic [ENW-1:0]    en_q;
    logic              clr, tick, wrap;
    logic [CW-1:0]     cnt;
    logic [NPH-1:0]    ph_state;
    logic              tgl_q;

    tpwm_cfg #(.CW(CW), .NPH(NPH)) u_cfg (
        .clk(clk), .rst_n(rst_n), .run(run), .we(cfg_we), .clr_req(cfg_clr),
        .presc_i(cfg_presc), .prd_i(cfg_period), .cmp_i(cfg_cmp),
        .pol_p_i(cfg_pol_p), .pol_n_i(cfg_pol_n), .tgl_en_i(cfg_tgl_en),
        .en_i(cfg_pin_en), .presc_o(presc_q), .prd_o(prd_q), .cmp_o(cmp_q),
        .pol_p_o(pol_p_q), .pol_n_o(pol_n_q), .tgl_en_o(tgl_en_q),
        .en_o(en_q), .clr_o(clr)
    );

    tpwm_tick u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .clr(clr), .sel(presc_q),
        .tick(tick)
    );

    tpwm_count #(.CW(CW)) u_count (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr), .prd(prd_q),
        .cnt(cnt), .wrap(wrap)
    );

    for (genvar g = 0; g < NPH; g++) begin : g_phase
        tpwm_phase #(.CW(CW)) u_phase (
            .clk(clk), .rst_n(rst_n), .tick(tick), .wrap(wrap), .cnt(cnt),
            .cmp(cmp_q[g*CW +: CW]), .prd(prd_q), .state(ph_state[g])
        );

        // Output stage: polarity, then enable gating to the inactive level.
        assign pha_p[g] = en_q[g]       ? (pol_p_q ? ph_state[g] : ~ph_state[g]) : ~pol_p_q;
        assign pha_n[g] = en_q[NPH + g] ? (pol_n_q ? ~ph_state[g] : ph_state[g]) : ~pol_n_q;

        // R4
        compl_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (en_q[g] && en_q[NPH + g] && (pol_p_q == pol_n_q)) |-> (pha_p[g] != pha_n[g]));
    end

    // Invert the cycle-toggle state on each wrap when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgl_q <= 1'b0;
        end else if (wrap && tgl_en_q) begin
            tgl_q <= ~tgl_q;
        end
    end

    assign cyc_tgl = en_q[2*NPH] & tgl_q;

    // R6
    tgl_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgl_q != $past(tgl_q)) |-> $past(wrap && tgl_en_q));
endmodule

// File: tb/tri_pwm_top_tb.sv
module tri_pwm_top_tb;
    localparam int CW  = 8;
    localparam int NPH = 3;
    localparam time CLK_HALF = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0, cfg_we = 1'b0, cfg_clr = 1'b0;
    logic [1:0] cfg_presc = '0;
    logic [CW-1:0] cfg_period = '0;
    logic [NPH*CW-1:0] cfg_cmp = '0;
    logic cfg_pol_p = 1'b1, cfg_pol_n = 1'b1, cfg_tgl_en = 1'b0;
    logic [2*NPH:0] cfg_pin_en = '0;
    logic [NPH-1:0] pha_p, pha_n;
    logic cyc_tgl;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_HALF) clk = ~clk;

    tri_pwm_top #(.CW(CW), .NPH(NPH)) u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we), .cfg_clr(cfg_clr),
        .cfg_presc(cfg_presc), .cfg_period(cfg_period), .cfg_cmp(cfg_cmp),
        .cfg_pol_p(cfg_pol_p), .cfg_pol_n(cfg_pol_n), .cfg_tgl_en(cfg_tgl_en),
        .cfg_pin_en(cfg_pin_en), .pha_p(pha_p), .pha_n(pha_n), .cyc_tgl(cyc_tgl)
    );

    function automatic logic [6:0] pins();
        return {cyc_tgl, pha_n, pha_p};
    endfunction

    task automatic check(input string req, input logic [6:0] got, input logic [6:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // Phase state after k ticks from reset (R2, R3).
    function automatic bit exp_state(int k, int p, int c);
        if (c == p) return ((k / (p + 1)) % 2) == 1;
        if (k < p + 1) return 1'b0;
        return (k % (p + 1)) <= c;
    endfunction

    // Pin vector from the phase states (R4, R5, R6).
    function automatic logic [6:0] exp_pins(bit [2:0] st, bit t, bit pp, bit pn, logic [6:0] en);
        logic [6:0] r;
        for (int i = 0; i < 3; i++) begin
            r[i]   = en[i]   ? (pp ? st[i] : ~st[i]) : ~pp;
            r[3+i] = en[3+i] ? (pn ? ~st[i] : st[i]) : ~pn;
        end
        r[6] = en[6] & t;
        return r;
    endfunction

    task automatic do_reset();
        run = 0; cfg_we = 0; cfg_clr = 0; rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic write_cfg(int s, int p, int c0, int c1, int c2, bit pp, bit pn, bit te, logic [6:0] en);
        cfg_presc = 2'(s); cfg_period = CW'(p);
        cfg_cmp = {CW'(c2), CW'(c1), CW'(c0)};
        cfg_pol_p = pp; cfg_pol_n = pn; cfg_tgl_en = te; cfg_pin_en = en;
        cfg_we = 1;
        @(negedge clk);
        cfg_we = 0;
    endtask

    initial begin : watchdog
        #(CLK_HALF * 2 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        int v;
        v = 0;
        do_reset();
        // R11: reset state drives all pins low.
        check("R11", pins(), 7'b0);

        for (int s = 0; s < 4; s++) begin
            for (int pi = 0; pi < 3; pi++) begin
                int p;
                p = (pi == 0) ? 0 : (pi == 1) ? 3 : 6;
                for (int c = 0; c <= p; c++) begin
                    int d, n, k, c1;
                    bit pp, pn, te;
                    logic [6:0] en, exp;
                    bit [2:0] st;
                    bit t;
                    logic [6:0] held;
                    d  = 1 << (2 * s);
                    n  = d * (2 * (p + 1) + c) + s;
                    k  = n / d;
                    c1 = (c + 1) % (p + 1);
                    pp = v[0]; pn = v[1]; te = v[2] | v[3];
                    en = ((v % 4) == 3) ? 7'((v * 37) & 7'h7F) : 7'h7F;
                    do_reset();
                    write_cfg(s, p, c, c1, p, pp, pn, te, en);
                    run = 1;
                    for (int i = 0; i < n; i++) begin
                        if ((v % 3) == 1 && i == 1) begin
                            // R8: set-up and clear strobes during a run are ignored.
                            cfg_period = CW'(p + 2); cfg_cmp = '1;
                            cfg_pol_p = ~pp; cfg_pin_en = ~en; cfg_clr = 1; cfg_we = 1;
                        end else begin
                            cfg_we = 0; cfg_clr = 0;
                        end
                        @(negedge clk);
                    end
                    run = 0; cfg_we = 0; cfg_clr = 0;
                    st[0] = exp_state(k, p, c);
                    st[1] = exp_state(k, p, c1);
                    st[2] = exp_state(k, p, p);
                    t  = te && (((k / (p + 1)) % 2) == 1);
                    exp = exp_pins(st, t, pp, pn, en);
                    if ((v % 3) == 1)
                        check("R8 R1 R2 R3 R4 R5 R6 R7", pins(), exp);
                    else
                        check("R1 R2 R3 R4 R5 R6 R7", pins(), exp);
                    held = pins();
                    repeat (5) @(negedge clk);
                    // R10: halted outputs hold.
                    check("R10", pins(), held);
                    v++;
                end
            end
        end

        // R9: halted clear restarts the count but keeps phase states.
        do_reset();
        write_cfg(0, 4, 2, 3, 4, 1'b1, 1'b1, 1'b1, 7'h7F);
        run = 1;
        repeat (7) @(negedge clk);
        run = 0;
        cfg_clr = 1;
        @(negedge clk);
        cfg_clr = 0;
        run = 1;
        repeat (2) @(negedge clk);
        run = 0;
        check("R9", pins(), 7'b1_000_111);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule